// File: doc/BRIEF.md
# Two-of-Four Structured Weight Pruner

This block compresses one row of signed neural-network weights into a fine-grained structured sparse form. The row is cut into consecutive groups of four columns. In every group the two weights with the largest absolute value survive, and the remaining two are dropped. For each group the block outputs the two surviving weights, unchanged, together with a 2-bit code per survivor that tells where it sat inside its group. A row of eight weights therefore becomes four weights plus eight bits of position metadata, which halves the weight storage a downstream sparse multiply-accumulate engine has to read.

Rows arrive on a valid/ready stream, one row per beat. Results leave through a single registered stage on a second valid/ready stream. The block accepts a new row on every cycle in which the output stage is empty or is being drained. When the consumer stalls, the output holds still. The weight width is a parameter: 8-bit and 16-bit signed weights are the intended settings.

Top module: `sparse24Pruner`

## Requirements
- R1: Input column c sits at `inRow[c*WEIGHT_W +: WEIGHT_W]`. Columns 0..3 form group 0 and columns 4..7 form group 1. Group g owns output slots 2g and 2g+1, which are `outVals[s*WEIGHT_W +: WEIGHT_W]` and `outIdx[s*2 +: 2]` for slot s.
- R2: In each group exactly the two elements with the largest absolute value are kept. The other two do not appear in the output.
- R3: When magnitudes are equal, the element at the lower column wins. A group whose four magnitudes are all equal therefore keeps positions 0 and 1.
- R4: The most negative weight (for example 0x80 at 8 bits) ranks above the most positive weight, because its magnitude is one larger.
- R5: Each position code is the kept element's index 0..3 within its group. Slot 2g holds the lower-positioned survivor and slot 2g+1 holds the higher one, so the two codes of a group are strictly ascending.
- R6: Kept weights are output bit-exact, with their sign preserved.
- R7: `inReady` is high exactly when `outValid` is low or `outReady` is high. A row accepted at a clock edge appears on the outputs with `outValid` high right after that same edge. Back-to-back rows are accepted one per cycle.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outVals` and `outIdx` hold their values.
- R9: During reset, `outValid`, `outVals` and `outIdx` are zero and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input row is valid |
| inReady | output | 1 | Block can accept a row |
| inRow | input | NUM_COLS*WEIGHT_W | Row of signed weights, column 0 in the low bits |
| outValid | output | 1 | Compressed row is valid |
| outReady | input | 1 | Consumer accepts the compressed row |
| outVals | output | NUM_COLS/2*WEIGHT_W | Kept weights, slot 0 in the low bits |
| outIdx | output | NUM_COLS | 2-bit position codes, slot 0 in the low bits |

## Verification
A wrong magnitude ranking shows up in the very next output beat. It appears either as a wrong survivor value or as a wrong position code. Tie rows and rows holding the most negative value are the inputs that expose it. A fault in the output stage or in the handshake shows up within one cycle as one of three symptoms: a lost row, a duplicated row, or an output that changes while the consumer is stalled. The bench therefore streams rows back to back and then holds a stall across several cycles.

// File: rtl/sparse24_pkg.sv
package sparse24_pkg;
  localparam int GROUP_SIZE = 4;
  localparam int KEEP_PER_GROUP = 2;
  localparam int POS_W = 2;

  typedef struct packed {
    logic load;
  } pruneStrobes_t;
endpackage

// File: rtl/pruneCtrl.sv
module pruneCtrl
  import sparse24_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic          outReady,
  output logic          outValid,
  output pruneStrobes_t strobes
);
  logic validQ;

  assign inReady      = !validQ || outReady;
  assign strobes.load = inValid && inReady;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobes.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> outValid); // R7
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R8
endmodule

// File: rtl/pruneDatapath.sv
module pruneDatapath
  import sparse24_pkg::*;
#(
  parameter int WEIGHT_W = 8,
  parameter int NUM_COLS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pruneStrobes_t                 strobes,
  input  logic [NUM_COLS*WEIGHT_W-1:0]  inRow,
  output logic [NUM_COLS/2*WEIGHT_W-1:0] outVals,
  output logic [NUM_COLS-1:0]           outIdx
);
  localparam int NUM_GROUPS = NUM_COLS / GROUP_SIZE;
  localparam int NUM_KEPT   = NUM_GROUPS * KEEP_PER_GROUP;
  localparam int MAG_W      = WEIGHT_W + 1;

  logic [NUM_KEPT*WEIGHT_W-1:0] nextVals;
  logic [NUM_KEPT*POS_W-1:0]    nextIdx;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [WEIGHT_W-1:0] elem [GROUP_SIZE];
    logic [MAG_W-1:0]    mag  [GROUP_SIZE];
    logic [GROUP_SIZE-1:0] keepMask;
    logic [POS_W-1:0]    loPos;
    logic [POS_W-1:0]    hiPos;

    for (genvar e = 0; e < GROUP_SIZE; e++) begin : gElem
      assign elem[e] = inRow[(g*GROUP_SIZE+e)*WEIGHT_W +: WEIGHT_W];
      // Magnitude in one extra bit so the most negative value stays exact.
      assign mag[e] = elem[e][WEIGHT_W-1] ? (~{1'b1, elem[e]} + 1'b1)
                                          : {1'b0, elem[e]};
    end

    always_comb begin
      for (int i = 0; i < GROUP_SIZE; i++) begin
        logic [2:0] beaten;
        beaten = '0;
        for (int j = 0; j < GROUP_SIZE; j++) begin
          if (j < i) begin
            if (mag[j] >= mag[i]) beaten = beaten + 3'd1;
          end else if (j > i) begin
            if (mag[j] > mag[i]) beaten = beaten + 3'd1;
          end
        end
        keepMask[i] = (beaten < 3'(KEEP_PER_GROUP));
      end
    end

    always_comb begin
      loPos = '0;
      hiPos = '0;
      for (int e = GROUP_SIZE - 1; e >= 0; e--) begin
        if (keepMask[e]) loPos = POS_W'(e);
      end
      for (int e = 0; e < GROUP_SIZE; e++) begin
        if (keepMask[e]) hiPos = POS_W'(e);
      end
    end

    assign nextVals[(2*g)*WEIGHT_W +: WEIGHT_W]   = elem[loPos];
    assign nextVals[(2*g+1)*WEIGHT_W +: WEIGHT_W] = elem[hiPos];
    assign nextIdx[(2*g)*POS_W +: POS_W]          = loPos;
    assign nextIdx[(2*g+1)*POS_W +: POS_W]        = hiPos;

    AST_KEEP_TWO: assert property (@(posedge clk) disable iff (!rstN)
      $countones(keepMask) == KEEP_PER_GROUP); // R2
    AST_POS_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
      strobes.load |=> (outIdx[(2*g)*POS_W +: POS_W] < outIdx[(2*g+1)*POS_W +: POS_W])); // R5
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVals <= '0;
      outIdx  <= '0;
    end else if (strobes.load) begin
      outVals <= nextVals;
      outIdx  <= nextIdx;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(outVals) && $stable(outIdx))); // R8
endmodule

// File: rtl/sparse24Pruner.sv
module sparse24Pruner
  import sparse24_pkg::*;
#(
  parameter int WEIGHT_W = 8,
  parameter int NUM_COLS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  output logic                           inReady,
  input  logic [NUM_COLS*WEIGHT_W-1:0]   inRow,
  output logic                           outValid,
  input  logic                           outReady,
  output logic [NUM_COLS/2*WEIGHT_W-1:0] outVals,
  output logic [NUM_COLS-1:0]            outIdx
);
  pruneStrobes_t strobes;

  pruneCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  pruneDatapath #(
    .WEIGHT_W (WEIGHT_W),
    .NUM_COLS (NUM_COLS)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inRow   (inRow),
    .outVals (outVals),
    .outIdx  (outIdx)
  );
endmodule

// File: tb/tb_sparse24Pruner.sv
`timescale 1ns/1ps
module tb_sparse24Pruner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inRow = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outVals;
  logic [7:0]  outIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sparse24Pruner dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inRow(inRow), .outValid(outValid), .outReady(outReady),
    .outVals(outVals), .outIdx(outIdx)
  );

  // Rows: column 0 in the low byte. Values: slot 0 low. Codes: slot 0 low.
  localparam int NV = 5;
  localparam logic [63:0] ROWS [NV] = '{
    64'h00F010FE02030501,  // R2 plain ranking
    64'h040302010100807F,  // R4 most negative beats most positive
    64'h05FB05FB05050505,  // R3 all ties
    64'h0000000000000000,  // R3 all zero
    64'h807F8100F7010009   // R2/R3/R6 outer positions, mixed signs
  };
  localparam logic [31:0] VALS [NV] = '{
    32'hF0100305, 32'h0403807F, 32'h05FB0505, 32'h00000000, 32'h8081F709
  };
  localparam logic [7:0] IDXS [NV] = '{
    8'h99, 8'hE4, 8'h44, 8'h44, 8'hDC
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset outValid", 64'(outValid), 64'd0);
    check("R9 reset outVals", 64'(outVals), 64'd0);
    check("R9 reset outIdx", 64'(outIdx), 64'd0);
    check("R9 reset inReady", 64'(inReady), 64'd1);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk, back-to-back rows, consumer always ready (R1, R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inRow   = ROWS[i];
      #1;
      check("R7 inReady streaming", 64'(inReady), 64'd1);
      @(posedge clk);
      #1;
      check("R7 outValid after accept", 64'(outValid), 64'd1);
      check("R1/R2/R6 outVals", 64'(outVals), 64'(VALS[i]));
      check("R1/R5 outIdx", 64'(outIdx), 64'(IDXS[i]));
    end

    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R7 drain clears outValid", 64'(outValid), 64'd0);

    // Backpressure (R7, R8)
    @(negedge clk);
    outReady = 1'b0;
    inValid  = 1'b1;
    inRow    = ROWS[1];
    @(posedge clk);
    #1;
    check("R4 row under stall", 64'(outVals), 64'(VALS[1]));
    @(negedge clk);
    inRow = ROWS[2];
    #1;
    check("R7 inReady low when full and stalled", 64'(inReady), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      check("R8 outValid held", 64'(outValid), 64'd1);
      check("R8 outVals held", 64'(outVals), 64'(VALS[1]));
      check("R8 outIdx held", 64'(outIdx), 64'(IDXS[1]));
    end
    @(negedge clk);
    outReady = 1'b1;
    #1;
    check("R7 inReady with consumer ready", 64'(inReady), 64'd1);
    @(posedge clk);
    #1;
    check("R3 next row after stall vals", 64'(outVals), 64'(VALS[2]));
    check("R3 next row after stall idx", 64'(outIdx), 64'(IDXS[2]));
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R7 final drain", 64'(outValid), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule